// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers interrupt requests from eight peripheral lines and turns them into a single request toward the processor. When the processor acknowledges, the controller picks the winning line. It marks that line as in service and returns an 8-bit identifying vector one cycle later.

Line priority works in one of two ways, chosen by a mode bit:

- **Fixed nesting:** line 0 is always the highest priority and line 7 the lowest.
- **Rotation:** the line whose service has just ended becomes the lowest priority, so lines take turns.

In either mode, a request is only presented when it outranks every line currently in service. Each line can be masked on its own. An end-of-service write releases the highest-priority in-service line.

A four-entry write-only register port sets the mode, the mask and the vector base, and carries the end-of-service command.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_req` and `vec_valid` are low, the mask is clear (all lines enabled), the vector base is zero and fixed mode is active.
- R2: A line becomes pending on a 0-to-1 transition of its `irq_in` bit. It stays pending after the input falls, until acknowledged. A line held high after acknowledge does not raise a new request.
- R3: In fixed mode (register 0 bit 0 = 0), the lowest-numbered pending unmasked line wins.
- R4: The vector is the base held in register 2 bits 7:3, placed in `vec_out[7:3]`, with the 3-bit winning line number in `vec_out[2:0]`.
- R5: An `int_ack` cycle while `int_req` is high does three things. It clears the winner's pending bit, marks it in service, and gives `vec_valid` high with the vector in the following cycle, for exactly one cycle.
- R6: `int_req` is asserted only when the best pending unmasked line ranks strictly above every in-service line. Equal or lower lines are held off.
- R7: A write to register 3 (data ignored) clears the in-service bit of the highest-ranked in-service line only.
- R8: In rotating mode (register 0 bit 0 = 1), a register 3 write makes the line it released the lowest priority. The line after it, in circular order, becomes the highest. The rotation starts with line 0 highest.
- R9: A line whose bit is 1 in register 1 raises no request but stays pending. Clearing its mask bit lets it request.
- R10: `int_ack` while `int_req` is low has no effect: `vec_valid` stays low and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Peripheral request lines, rising-edge sensitive |
| int_ack | input | 1 | Processor acknowledge, one cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 mode, 1 mask, 2 vector base, 3 end of service |
| cfg_wdata | input | 8 | Register write data |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the acknowledged line |
| vec_valid | output | 1 | High for one cycle when `vec_out` carries a new vector |

## Verification
The bench exercises each of the following cases, each of which an error in the design would make visible:
- A line held high across its own service; a controller that sampled levels would interrupt again.
- Nesting with a pending request of equal rank and one of lower rank; a design that compares with "less than or equal" or ignores in-service state would let them through.
- Two lines in service, where end-of-service must release the higher one; a release of the lower or of both would show when a middle-ranked request then arrives.
- Rotating order after several releases, where a fixed-order winner would differ.
- Masked lines that must survive masking.
- An acknowledge with nothing pending, which must produce no vector.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int LINES = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             int_ack,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic             int_req,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int BASE_W = VEC_W - IDX_W;

  logic [LINES-1:0]  irq_q, pend, isr, mask;
  logic              rot;
  logic [IDX_W-1:0]  low_ptr, top_base;
  logic [BASE_W-1:0] vbase;

  function automatic logic [IDX_W:0] pick(input logic [LINES-1:0] v,
                                          input logic [IDX_W-1:0] b);
    logic [IDX_W:0]   r;
    logic [IDX_W-1:0] i;
    r = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      i = b + IDX_W'(k);
      if (v[i]) r = {1'b1, i};
    end
    return r;
  endfunction

  logic [IDX_W:0]   cand, top_isr;
  logic [IDX_W-1:0] cand_i, isr_i, cand_rank, isr_rank;
  logic             take, eoi, eoi_hit;

  assign top_base  = rot ? low_ptr + 1'b1 : '0;
  assign cand      = pick(pend & ~mask, top_base);
  assign top_isr   = pick(isr, top_base);
  assign cand_i    = cand[IDX_W-1:0];
  assign isr_i     = top_isr[IDX_W-1:0];
  assign cand_rank = cand_i - top_base;
  assign isr_rank  = isr_i - top_base;
  assign int_req   = cand[IDX_W] && (!top_isr[IDX_W] || cand_rank < isr_rank);
  assign take      = int_ack && int_req;
  assign eoi       = cfg_we && cfg_addr == 2'd3;
  assign eoi_hit   = eoi && top_isr[IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= '0;
      pend      <= '0;
      isr       <= '0;
      mask      <= '0;
      rot       <= 1'b0;
      low_ptr   <= IDX_W'(LINES - 1);
      vbase     <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      irq_q     <= irq_in;
      pend      <= (pend & ~(take ? LINES'(1) << cand_i : '0)) | (irq_in & ~irq_q);
      isr       <= (isr & ~(eoi_hit ? LINES'(1) << isr_i : '0))
                   | (take ? LINES'(1) << cand_i : '0);
      vec_valid <= take;
      if (take) vec_out <= {vbase, cand_i};
      if (eoi_hit && rot) low_ptr <= isr_i;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0:    rot   <= cfg_wdata[0];
          2'd1:    mask  <= cfg_wdata[LINES-1:0];
          2'd2:    vbase <= cfg_wdata[7:8-BASE_W];
          default: ;
        endcase
      end
    end
  end
endmodule

module prio_irq_ctrl_chk #(
  parameter int LINES = 8,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             int_ack,
  input logic             int_req,
  input logic             vec_valid,
  input logic [VEC_W-1:0] vec_out,
  input logic [LINES-1:0] pend,
  input logic [LINES-1:0] isr,
  input logic [LINES-1:0] mask
);
  localparam int IDX_W = $clog2(LINES);

  AST_ACK_GIVES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req) |=> vec_valid); // R5
  AST_NO_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_ack && int_req) |=> !vec_valid); // R10
  AST_VEC_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> isr[vec_out[IDX_W-1:0]]); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((pend & ~mask) != '0)); // R9
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.LINES(LINES), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .int_req(int_req),
  .vec_valid(vec_valid), .vec_out(vec_out), .pend(pend), .isr(isr), .mask(mask));

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic       clk = 0, rst_n = 0, int_ack = 0, cfg_we = 0;
  logic [7:0] irq_in = 0, cfg_wdata = 0;
  logic [1:0] cfg_addr = 0;
  logic       int_req, vec_valid;
  logic [7:0] vec_out;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_ack(int_ack),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .int_req(int_req), .vec_out(vec_out), .vec_valid(vec_valid));

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; irq_in = 0; int_ack = 0; cfg_we = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic eoi(); wr(2'd3, 8'h00); endtask

  task automatic raise(input logic [7:0] m);
    @(negedge clk); irq_in = m;
    @(negedge clk); irq_in = 0;
  endtask

  task automatic ack_expect(input string req, input int exp_vec);
    @(negedge clk); int_ack = 1;
    @(negedge clk); int_ack = 0;
    check({req, " vec_valid"}, vec_valid, 1);
    check({req, " vector"}, vec_out, exp_vec);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R1 int_req", int_req, 0);
    check("R1 vec_valid", vec_valid, 0);
  endtask

  task automatic t_fixed();
    do_reset();
    raise(8'b1010_0100);
    check("R2 pending after edge", int_req, 1);
    ack_expect("R3 first", 2); eoi();
    ack_expect("R3 second", 5); eoi();
    ack_expect("R3 third", 7); eoi();
    @(negedge clk);
    check("R5 pending cleared", int_req, 0);
  endtask

  task automatic t_level();
    do_reset();
    @(negedge clk); irq_in = 8'h08;
    repeat (2) @(negedge clk);
    check("R2 level latched", int_req, 1);
    ack_expect("R2 level vec", 3);
    eoi();
    repeat (2) @(negedge clk);
    check("R2 held high no retrigger", int_req, 0);
    irq_in = 0; @(negedge clk); irq_in = 8'h08; @(negedge clk);
    check("R2 new edge", int_req, 1);
    irq_in = 0;
  endtask

  task automatic t_vector();
    do_reset();
    wr(2'd2, 8'hC8);
    raise(8'h40);
    ack_expect("R4 base and line", 8'hCE);
  endtask

  task automatic t_nest();
    do_reset();
    raise(8'h10);
    ack_expect("R6 first", 4);
    raise(8'h40);
    check("R6 lower held", int_req, 0);
    raise(8'h10);
    check("R6 equal held", int_req, 0);
    raise(8'h02);
    check("R6 higher passes", int_req, 1);
    ack_expect("R6 nested", 1);
    eoi();
    @(negedge clk);
    check("R7 still held after release", int_req, 0);
    raise(8'h04);
    check("R7 only top released", int_req, 1);
    ack_expect("R7 middle", 2);
    eoi(); eoi();
    ack_expect("R6 equal later", 4); eoi();
    ack_expect("R6 lower later", 6); eoi();
  endtask

  task automatic t_mask();
    do_reset();
    wr(2'd1, 8'h08);
    raise(8'h08);
    check("R9 masked quiet", int_req, 0);
    raise(8'h20);
    check("R9 other line", int_req, 1);
    ack_expect("R9 other vec", 5); eoi();
    @(negedge clk);
    check("R9 still masked", int_req, 0);
    wr(2'd1, 8'h00);
    check("R9 unmasked", int_req, 1);
    ack_expect("R9 kept pending", 3); eoi();
  endtask

  task automatic t_spurious();
    do_reset();
    @(negedge clk); int_ack = 1;
    @(negedge clk); int_ack = 0;
    check("R10 no vector", vec_valid, 0);
    check("R10 no request", int_req, 0);
  endtask

  task automatic t_rotate();
    do_reset();
    wr(2'd0, 8'h01);
    raise(8'h24);
    ack_expect("R8 start order", 2); eoi();
    raise(8'h05);
    ack_expect("R8 after rotate", 5); eoi();
    ack_expect("R8 wrap", 0); eoi();
    ack_expect("R8 last", 2); eoi();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fixed();
    t_level();
    t_vector();
    t_nest();
    t_mask();
    t_spurious();
    t_rotate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule